// File: doc/BRIEF.md
# Load/Store Ordering Queue

This block sits between address generation and the level-one data cache and decides when each memory operation may touch the cache. Stores enter an eight-entry queue in program order. Each store waits there until the completion logic retires it with a pulse on `st_retire`. Retired stores then leave from the head, one per cycle at most, through a two-stage drain pipe to the cache write port.

Loads are accepted one at a time in program order. A load may reach the cache ahead of older stores that are still waiting, but only if three conditions hold. Its page must not be guarded. No store in the queue or drain pipe may share its doubleword address. The synchronize input must be low. A guarded load, a synchronized load, or a load whose doubleword is still held by a store waits until it is no longer blocked. Read data returns from the cache after a fixed latency into a single holding slot. It stays there until the completion logic releases it with `ld_retire`.

A flush drops the stores that have not been retired and any pending load. Stores that were already retired stay and still drain to the cache.

The load side is a four-state machine. IDLE moves to ISSUE when a load is accepted. ISSUE moves to WAIT unconditionally on the next edge, and WAIT moves to HOLD when the cache response is valid. HOLD moves back to IDLE on `ld_retire`. A flush forces any state back to IDLE.

Top module: `mem_order_queue`

## Requirements
- R1: Stores appear on the cache write port strictly in the order they were accepted, each with its own address and data, and at most one store appears per cycle.
- R2: No store reaches the write port before a retire pulse has marked it. Each `st_retire` pulse marks the oldest unmarked store in the queue. A pulse when every held store is already marked, or a pulse during a flush, has no effect.
- R3: A marked store at the queue head leaves the queue at the next edge. It shows on the write port for one cycle, starting two edges after it leaves. A store retired alone in cycle n is written in cycle n+3, and stores retired on consecutive cycles are written on consecutive cycles.
- R4: The queue holds 8 stores. `st_ready` is high while fewer than 8 stores are queued and low when 8 are queued.
- R5: A load with `ld_guarded` low, `sync_req` low and no doubleword match is accepted in the same cycle when the load side is idle, even while older stores are queued.
- R6: A load is not accepted while any queued or draining store has the same doubleword address, where the doubleword address is address bits 31 to 3.
- R7: A load with `ld_guarded` high is not accepted until no store is queued or draining.
- R8: While `sync_req` is high, no load is accepted until no store is queued or draining.
- R9: A load accepted at edge T drives `dc_rd_valid` with its address during the cycle after T only. The cache response is captured at edge T+2. `ld_hold_valid` stays high with that data until `ld_retire`. While a load is in flight or held, `ld_ready` is low.
- R10: During a `flush` cycle, `st_ready` and `ld_ready` are low. After the flush edge, unretired stores are never written, retired stores still drain, and a pending or held load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store request taken this cycle |
| st_addr | input | 32 | Store byte address |
| st_data | input | 64 | Store data |
| st_retire | input | 1 | Completion marks the oldest unmarked store |
| ld_valid | input | 1 | Load request present |
| ld_ready | output | 1 | Load request issued this cycle |
| ld_addr | input | 32 | Load byte address |
| ld_guarded | input | 1 | Page of the load is guarded |
| sync_req | input | 1 | Synchronize: no load may pass a store |
| flush | input | 1 | Drop unretired stores and the pending load |
| ld_retire | input | 1 | Completion releases the held load data |
| ld_hold_valid | output | 1 | Holding slot contains load data |
| ld_hold_data | output | 64 | Held load data |
| dc_wr_valid | output | 1 | Cache write strobe |
| dc_wr_addr | output | 32 | Cache write address |
| dc_wr_data | output | 64 | Cache write data |
| dc_rd_valid | output | 1 | Cache read strobe |
| dc_rd_addr | output | 32 | Cache read address |
| dc_rd_ack | input | 1 | Cache read data valid, one cycle after the read strobe |
| dc_rd_data | input | 64 | Cache read data |

## Verification
The checks are timed from where each effect is due:
- `ld_ready` is combinational from the current inputs and queue contents, so it is checked in the same cycle as the request.
- The cache read strobe is expected in the cycle after an accepted load.
- The holding slot is expected to fill in the third cycle counted from the accept cycle, with the data the cache held at that time.
- A store is expected on the write port no earlier than three cycles after the cycle of its retire pulse. In the directed run, where stores are retired one per cycle with no backlog, it is expected exactly three cycles after.

All outputs are sampled on the falling edge. A reference model applies each cycle's events after that cycle's checks, so every comparison uses the state that existed before the coming rising edge.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    // lowest address bit that selects a doubleword
    parameter int unsigned DW_LSB = 3;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_ISSUE,
        LD_WAIT,
        LD_HOLD
    } ld_state_e;

endpackage

// File: rtl/lsq_store_buf.sv
module lsq_store_buf #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              retire,
    input  logic              flush,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              pop,
    output logic [ADDR_W-1:0] pop_addr,
    output logic [DATA_W-1:0] pop_data,
    output logic              full,
    output logic              empty,
    output logic              probe_hit,
    output logic [CNT_W-1:0]  held_cnt,
    output logic [CNT_W-1:0]  done_cnt
);
    import lsq_pkg::*;

    localparam int PTR_W = $clog2(DEPTH);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [PTR_W-1:0]  head_q, tail_q;
    logic [CNT_W-1:0]  cnt_q, done_q;
    logic              pop_w, retire_ok;
    logic [DEPTH-1:0]  hit_vec;

    // any retired entry sits at the head, so a retired count drives the pop
    assign pop_w     = (done_q != '0);
    assign retire_ok = retire && !flush && (done_q < cnt_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            done_q <= '0;
        end else begin
            head_q <= head_q + PTR_W'(pop_w);
            if (flush) begin
                tail_q <= head_q + done_q[PTR_W-1:0];
                cnt_q  <= done_q - CNT_W'(pop_w);
                done_q <= done_q - CNT_W'(pop_w);
            end else begin
                tail_q <= tail_q + PTR_W'(push);
                cnt_q  <= cnt_q + CNT_W'(push) - CNT_W'(pop_w);
                done_q <= done_q - CNT_W'(pop_w) + CNT_W'(retire_ok);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            addr_q[tail_q] <= push_addr;
            data_q[tail_q] <= push_data;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        logic [PTR_W-1:0] off;
        assign off = PTR_W'(i) - head_q;
        assign hit_vec[i] = (CNT_W'(off) < cnt_q) &&
                            (addr_q[i][ADDR_W-1:DW_LSB] == probe_addr[ADDR_W-1:DW_LSB]);
    end

    assign pop       = pop_w;
    assign pop_addr  = addr_q[head_q];
    assign pop_data  = data_q[head_q];
    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign empty     = (cnt_q == '0);
    assign probe_hit = |hit_vec;
    assign held_cnt  = cnt_q;
    assign done_cnt  = done_q;

endmodule

// File: rtl/lsq_drain_pipe.sv
module lsq_drain_pipe #(
    parameter int STAGES = 2,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic              probe_hit,
    output logic              busy
);
    import lsq_pkg::*;

    logic [STAGES-1:0] v_q;
    logic [ADDR_W-1:0] a_q [STAGES];
    logic [DATA_W-1:0] d_q [STAGES];
    logic [STAGES-1:0] hit_vec;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic              v_in;
        logic [ADDR_W-1:0] a_in;
        logic [DATA_W-1:0] d_in;
        if (s == 0) begin : g_first
            assign v_in = in_valid;
            assign a_in = in_addr;
            assign d_in = in_data;
        end else begin : g_next
            assign v_in = v_q[s-1];
            assign a_in = a_q[s-1];
            assign d_in = d_q[s-1];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) v_q[s] <= 1'b0;
            else        v_q[s] <= v_in;
        end

        always_ff @(posedge clk) begin
            a_q[s] <= a_in;
            d_q[s] <= d_in;
        end

        assign hit_vec[s] = v_q[s] &&
                            (a_q[s][ADDR_W-1:DW_LSB] == probe_addr[ADDR_W-1:DW_LSB]);
    end

    assign out_valid = v_q[STAGES-1];
    assign out_addr  = a_q[STAGES-1];
    assign out_data  = d_q[STAGES-1];
    assign probe_hit = |hit_vec;
    assign busy      = |v_q;

endmodule

// File: rtl/lsq_load_ctrl.sv
module lsq_load_ctrl #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_guarded,
    input  logic                    sync_req,
    input  logic                    flush,
    input  logic                    st_conflict,
    input  logic                    st_empty,
    input  logic                    rsp_valid,
    input  logic [DATA_W-1:0]       rsp_data,
    input  logic                    release_hold,
    output logic                    req_ready,
    output logic                    rd_valid,
    output logic [ADDR_W-1:0]       rd_addr,
    output logic                    hold_valid,
    output logic [DATA_W-1:0]       hold_data,
    output lsq_pkg::ld_state_e      state_o
);
    import lsq_pkg::*;

    ld_state_e         state_q, state_d;
    logic              may_issue;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    assign may_issue = !flush && !st_conflict &&
                       (st_empty || (!req_guarded && !sync_req));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:  if (req_valid && may_issue) state_d = LD_ISSUE;
            LD_ISSUE: state_d = LD_WAIT;
            LD_WAIT:  if (rsp_valid) state_d = LD_HOLD;
            LD_HOLD:  if (release_hold) state_d = LD_IDLE;
            default:  state_d = LD_IDLE;
        endcase
        if (flush) state_d = LD_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready  = 1'b0;
        rd_valid   = 1'b0;
        hold_valid = 1'b0;
        unique case (state_q)
            LD_IDLE:  req_ready  = may_issue;
            LD_ISSUE: rd_valid   = 1'b1;
            LD_WAIT:  ;
            LD_HOLD:  hold_valid = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (state_q == LD_IDLE && req_valid && may_issue) addr_q <= req_addr;
        if (state_q == LD_WAIT && rsp_valid && !flush)    data_q <= rsp_data;
    end

    assign rd_addr   = addr_q;
    assign hold_data = data_q;
    assign state_o   = state_q;

endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue #(
    parameter int DEPTH        = 8,
    parameter int ADDR_W       = 32,
    parameter int DATA_W       = 64,
    parameter int DRAIN_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              st_retire,
    input  logic              ld_valid,
    output logic              ld_ready,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              ld_guarded,
    input  logic              sync_req,
    input  logic              flush,
    input  logic              ld_retire,
    output logic              ld_hold_valid,
    output logic [DATA_W-1:0] ld_hold_data,
    output logic              dc_wr_valid,
    output logic [ADDR_W-1:0] dc_wr_addr,
    output logic [DATA_W-1:0] dc_wr_data,
    output logic              dc_rd_valid,
    output logic [ADDR_W-1:0] dc_rd_addr,
    input  logic              dc_rd_ack,
    input  logic [DATA_W-1:0] dc_rd_data
);
    import lsq_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              buf_full, buf_empty, buf_pop, buf_hit;
    logic [ADDR_W-1:0] buf_pop_addr;
    logic [DATA_W-1:0] buf_pop_data;
    logic [CNT_W-1:0]  buf_held_cnt, buf_done_cnt;
    logic              pipe_hit, pipe_busy;
    logic              st_push, ld_accept, stores_empty;
    ld_state_e         ld_state;

    assign st_ready     = !buf_full && !flush;
    assign st_push      = st_valid && st_ready;
    assign stores_empty = buf_empty && !pipe_busy;
    assign ld_accept    = ld_valid && ld_ready;

    lsq_store_buf #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_store_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (st_push),
        .push_addr  (st_addr),
        .push_data  (st_data),
        .retire     (st_retire),
        .flush      (flush),
        .probe_addr (ld_addr),
        .pop        (buf_pop),
        .pop_addr   (buf_pop_addr),
        .pop_data   (buf_pop_data),
        .full       (buf_full),
        .empty      (buf_empty),
        .probe_hit  (buf_hit),
        .held_cnt   (buf_held_cnt),
        .done_cnt   (buf_done_cnt)
    );

    lsq_drain_pipe #(
        .STAGES(DRAIN_STAGES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (buf_pop),
        .in_addr    (buf_pop_addr),
        .in_data    (buf_pop_data),
        .probe_addr (ld_addr),
        .out_valid  (dc_wr_valid),
        .out_addr   (dc_wr_addr),
        .out_data   (dc_wr_data),
        .probe_hit  (pipe_hit),
        .busy       (pipe_busy)
    );

    lsq_load_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_load (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (ld_valid),
        .req_addr     (ld_addr),
        .req_guarded  (ld_guarded),
        .sync_req     (sync_req),
        .flush        (flush),
        .st_conflict  (buf_hit || pipe_hit),
        .st_empty     (stores_empty),
        .rsp_valid    (dc_rd_ack),
        .rsp_data     (dc_rd_data),
        .release_hold (ld_retire),
        .req_ready    (ld_ready),
        .rd_valid     (dc_rd_valid),
        .rd_addr      (dc_rd_addr),
        .hold_valid   (ld_hold_valid),
        .hold_data    (ld_hold_data),
        .state_o      (ld_state)
    );

endmodule

// File: rtl/lsq_order_chk.sv
module lsq_order_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] held_cnt,
    input logic [CNT_W-1:0] done_cnt,
    input logic             pop,
    input logic             wr_valid,
    input logic             ld_accept,
    input logic             buf_hit,
    input logic             pipe_hit,
    input logic             stores_empty,
    input logic             guarded,
    input logic             sync_req,
    input logic             flush,
    input logic             rd_valid,
    input logic             hold_valid
);
    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held_cnt <= CNT_W'(DEPTH));

    // R2
    retired_within_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_cnt <= held_cnt);

    // R3
    drain_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> ##2 wr_valid);

    // R3
    write_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(pop, 2));

    // R6
    ld_no_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_accept |-> !(buf_hit || pipe_hit));

    // R7
    ld_guarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_accept && guarded) |-> stores_empty);

    // R8
    ld_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_accept && sync_req) |-> stores_empty);

    // R9
    ld_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_accept |=> rd_valid);

    // R9
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R10
    flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hold_valid);

    // R10
    flush_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (held_cnt == $past(done_cnt) - CNT_W'($past(pop))));
endmodule

bind mem_order_queue lsq_order_chk #(
    .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_order_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .held_cnt     (buf_held_cnt),
    .done_cnt     (buf_done_cnt),
    .pop          (buf_pop),
    .wr_valid     (dc_wr_valid),
    .ld_accept    (ld_accept),
    .buf_hit      (buf_hit),
    .pipe_hit     (pipe_hit),
    .stores_empty (stores_empty),
    .guarded      (ld_guarded),
    .sync_req     (sync_req),
    .flush        (flush),
    .rd_valid     (dc_rd_valid),
    .hold_valid   (ld_hold_valid)
);

// File: tb/tb_mem_order_queue.sv
module tb_mem_order_queue;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 0, st_retire = 0, ld_valid = 0, ld_guarded = 0;
    logic        sync_req = 0, flush = 0, ld_retire = 0, dc_rd_ack;
    logic [31:0] st_addr = '0, ld_addr = '0, dc_wr_addr, dc_rd_addr;
    logic [63:0] st_data = '0, ld_hold_data, dc_wr_data, dc_rd_data;
    logic        st_ready, ld_ready, ld_hold_valid, dc_wr_valid, dc_rd_valid;

    always #10 clk = ~clk;

    mem_order_queue dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .st_retire(st_retire),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_guarded(ld_guarded),
        .sync_req(sync_req), .flush(flush), .ld_retire(ld_retire),
        .ld_hold_valid(ld_hold_valid), .ld_hold_data(ld_hold_data),
        .dc_wr_valid(dc_wr_valid), .dc_wr_addr(dc_wr_addr), .dc_wr_data(dc_wr_data),
        .dc_rd_valid(dc_rd_valid), .dc_rd_addr(dc_rd_addr),
        .dc_rd_ack(dc_rd_ack), .dc_rd_data(dc_rd_data)
    );

    // cache model: one-cycle read, write on the strobe edge
    logic [63:0] cmem [16];
    logic [63:0] ref_mem [16];
    always_ff @(posedge clk) begin
        if (!rst_n) dc_rd_ack <= 1'b0;
        else        dc_rd_ack <= dc_rd_valid;
        if (dc_rd_valid) dc_rd_data <= cmem[dc_rd_addr[6:3]];
        if (dc_wr_valid) cmem[dc_wr_addr[6:3]] <= dc_wr_data;
    end

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0, exact_gap = 0;

    // reference store list: queued plus draining, oldest first
    logic [31:0] sq_addr [$];
    logic [63:0] sq_data [$];
    bit          sq_done [$];
    int          sq_ccyc [$];

    bit          ld_pend = 0, ld_hold = 0;
    int          ld_acc = 0;
    logic [31:0] ld_a;
    logic [63:0] ld_x;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    function automatic bit has_conflict(input logic [31:0] a);
        for (int i = 0; i < sq_addr.size(); i++)
            if (sq_addr[i][31:3] == a[31:3]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] mk_addr(input int dw, input int lo);
        return {25'd0, 4'(dw), 3'(lo)};
    endfunction

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit conf, emp, busy, exp_rdy, exp_rd;
            string tag;
            cyc++;
            conf = has_conflict(ld_addr);
            emp  = (sq_addr.size() == 0);
            busy = ld_pend || ld_hold;
            exp_rdy = !busy && !flush && !conf && (emp || (!ld_guarded && !sync_req));
            tag = busy ? "R9" : flush ? "R10" : conf ? "R6" :
                  (ld_guarded && !emp) ? "R7" : (sync_req && !emp) ? "R8" : "R5";
            chk(ld_ready == exp_rdy, tag, 64'(ld_ready), 64'(exp_rdy));
            if (flush) chk(!st_ready, "R10 st_ready", 64'(st_ready), 0);
            else if (sq_addr.size() < 8) chk(st_ready, "R4 st_ready", 64'(st_ready), 1);
            exp_rd = ld_pend && (cyc == ld_acc + 1);
            chk(dc_rd_valid == exp_rd, "R9 read strobe", 64'(dc_rd_valid), 64'(exp_rd));
            if (exp_rd && dc_rd_valid) chk(dc_rd_addr == ld_a, "R9 read addr", 64'(dc_rd_addr), 64'(ld_a));
            chk(ld_hold_valid == ld_hold, "R9 hold valid", 64'(ld_hold_valid), 64'(ld_hold));
            if (ld_hold && ld_hold_valid) chk(ld_hold_data == ld_x, "R9 hold data", ld_hold_data, ld_x);
            if (dc_wr_valid) begin
                if (sq_addr.size() == 0) chk(0, "R1 unexpected write", 64'(dc_wr_addr), 0);
                else begin
                    int gap;
                    gap = cyc - sq_ccyc[0];
                    chk(dc_wr_addr == sq_addr[0], "R1 write addr", 64'(dc_wr_addr), 64'(sq_addr[0]));
                    chk(dc_wr_data == sq_data[0], "R1 write data", dc_wr_data, sq_data[0]);
                    chk(sq_done[0], "R2 retired before write", 64'(sq_done[0]), 1);
                    chk(sq_done[0] && gap >= 3, "R3 min latency", 64'(gap), 3);
                    if (exact_gap) chk(gap == 3, "R3 exact latency", 64'(gap), 3);
                    ref_mem[sq_addr[0][6:3]] = sq_data[0];
                    void'(sq_addr.pop_front()); void'(sq_data.pop_front());
                    void'(sq_done.pop_front()); void'(sq_ccyc.pop_front());
                end
            end
            if (ld_hold && ld_retire) ld_hold = 0;
            if (flush) begin
                ld_pend = 0; ld_hold = 0;
                while (sq_done.size() > 0 && !sq_done[sq_done.size()-1]) begin
                    void'(sq_addr.pop_back()); void'(sq_data.pop_back());
                    void'(sq_done.pop_back()); void'(sq_ccyc.pop_back());
                end
            end else begin
                if (ld_pend && cyc == ld_acc + 2) begin ld_pend = 0; ld_hold = 1; end
                if (st_retire)
                    for (int i = 0; i < sq_done.size(); i++)
                        if (!sq_done[i]) begin sq_done[i] = 1; sq_ccyc[i] = cyc; break; end
                if (st_valid && st_ready) begin
                    sq_addr.push_back(st_addr); sq_data.push_back(st_data);
                    sq_done.push_back(0); sq_ccyc.push_back(0);
                end
                if (ld_valid && ld_ready) begin
                    ld_pend = 1; ld_acc = cyc; ld_a = ld_addr; ld_x = ref_mem[ld_addr[6:3]];
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic idle_inputs();
        st_valid = 0; st_retire = 0; ld_valid = 0; ld_guarded = 0;
        sync_req = 0; flush = 0; ld_retire = 0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            cmem[i] = {32'hC0DE_0000 + 32'(i), 32'h5A5A_0000 + 32'(i)};
            ref_mem[i] = cmem[i];
        end
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1 rst_n = 1;

        // reset state
        @(negedge clk); #1;
        chk(st_ready, "R4 reset ready", 64'(st_ready), 1);
        chk(!dc_wr_valid, "R1 reset write idle", 64'(dc_wr_valid), 0);
        chk(!ld_hold_valid && !dc_rd_valid, "R9 reset load idle", 64'(ld_hold_valid), 0);
        chk(ld_ready, "R5 reset load ready", 64'(ld_ready), 1);
        tick();

        // fill queue with 8 unretired stores (R4)
        for (int i = 0; i < 8; i++) begin
            st_valid = 1; st_addr = mk_addr(i, i); st_data = {32'hABCD_0000, 32'(i)};
            tick();
        end
        st_addr = mk_addr(9, 0);
        @(negedge clk); #1;
        chk(!st_ready, "R4 full backpressure", 64'(st_ready), 0);
        tick();
        st_valid = 0;

        // bypass load (R5), then release it
        ld_valid = 1; ld_addr = mk_addr(12, 4); tick();
        ld_valid = 0; ld_retire = 1; repeat (4) tick();
        ld_retire = 0;
        // conflict (R6), guarded (R7), sync (R8)
        ld_valid = 1; ld_addr = mk_addr(3, 6); tick();
        ld_addr = mk_addr(13, 0); ld_guarded = 1; tick();
        ld_guarded = 0; sync_req = 1; tick();
        sync_req = 0; ld_valid = 0;

        // retire one per cycle: exact three-cycle latency, back-to-back writes (R3)
        exact_gap = 1; st_retire = 1;
        repeat (8) tick();
        st_retire = 0;
        repeat (6) tick();
        exact_gap = 0;
        chk(sq_addr.size() == 0, "R1 all drained", 64'(sq_addr.size()), 0);

        // flush: one retired store survives, two dropped, pending load dropped (R10)
        st_valid = 1; st_addr = mk_addr(1, 0); st_data = 64'h1111; tick();
        st_addr = mk_addr(2, 0); st_data = 64'h2222; st_retire = 1; tick();
        st_addr = mk_addr(3, 0); st_data = 64'h3333; st_retire = 0; tick();
        st_valid = 0; ld_valid = 1; ld_addr = mk_addr(7, 0); tick();
        ld_valid = 0; flush = 1; tick();
        flush = 0; repeat (8) tick();
        chk(sq_addr.size() == 0, "R10 only retired stores written", 64'(sq_addr.size()), 0);
        chk(ref_mem[2] == cmem[2] && cmem[3] != 64'h3333, "R10 dropped store not written",
            cmem[3], 64'h3333);

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            st_valid   = ($urandom % 3) == 0;
            st_addr    = mk_addr($urandom % 16, $urandom % 8);
            st_data    = {$urandom, $urandom};
            st_retire  = ($urandom % 3) == 0;
            ld_valid   = ($urandom % 2) == 0;
            ld_addr    = mk_addr($urandom % 16, $urandom % 8);
            ld_guarded = ($urandom % 8) == 0;
            sync_req   = ($urandom % 16) == 0;
            ld_retire  = ($urandom % 3) == 0;
            flush      = ($urandom % 64) == 0;
            tick();
        end

        // drain everything
        idle_inputs(); st_retire = 1; ld_retire = 1;
        repeat (20) tick();
        idle_inputs(); repeat (4) tick();
        chk(sq_addr.size() == 0, "R2 retired stores drained", 64'(sq_addr.size()), 0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

endmodule